// File: doc/BRIEF.md
# Shadow-Latched Real-Time Clock

This block is a real-time clock seen by software through a small word-addressed register window. A one-cycle strobe at the 32 kHz reference rate (`ref_tick`) drives a fractional accumulator. The accumulator advances a milliseconds counter that runs from 0 to 999, and each wrap of that counter advances a 32-bit seconds counter. The live counters stay inside the block. Software reads a published copy of them. This copy is refreshed once every eight reference strobes, in a short window of system clocks during which a busy flag is raised.

Software takes a consistent time pair by reading milliseconds first. That read also copies the published seconds into a shadow register, which software then reads. The block holds two seconds alarm compares and one milliseconds alarm compare. Each alarm sets a bit in a status register that software clears by writing ones. A mask register gates which status bits drive the active-high level interrupt. Two further mask and status positions are reserved for countdown events: the mask keeps them, but the status never sets them.

Top module: `rtc_shadow_timer`

## Requirements
- R1: After reset every readable register reads 0 (busy 0x04, seconds 0x08, shadow 0x0C, milliseconds 0x10, seconds alarm0 0x14, seconds alarm1 0x18, milliseconds alarm 0x1C, mask 0x28, status 0x2C) and `irq` is low.
- R2: The milliseconds value stays within 0..999. It advances by MS_PER_SEC/REF_HZ of a step per `ref_tick`, through an accumulator that is cleared whenever milliseconds are written. A written value above 999 is stored as 999.
- R3: Each wrap of milliseconds from 999 to 0 increments seconds. Seconds wrap from 0xFFFFFFFF to 0.
- R4: Bit 0 of register 0x04 is 1 for exactly BUSY_CLKS system clocks once every COPY_TICKS reference strobes. At the end of that window the seconds (0x08) and milliseconds (0x10) read values are refreshed from the live counters.
- R5: A write to seconds, milliseconds or any alarm register while busy is 1 is dropped, and the register keeps its value. Outside the window such writes take effect.
- R6: A read of 0x10 loads the current seconds read value into the shadow register (0x0C). The shadow is not writable and changes on no other access.
- R7: When seconds advance to a value equal to a nonzero seconds alarm, the status bit is set: bit 0 for alarm0, bit 1 for alarm1. An alarm value of 0 never fires.
- R8: When milliseconds advance to a value equal to a nonzero milliseconds alarm (0x1C, 10 bits), status bit 2 is set.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it. An alarm event arriving in the same cycle wins over the clear.
- R10: `irq` is high exactly while some status bit and the same mask bit are both 1.
- R11: The mask register keeps bits 4:0, and other bits read 0. Status bits 3 and 4 (countdown events) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per 32 kHz reference period |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt, active high |

## Verification
The checks assume that `ref_tick` is a one-cycle pulse and that it comes sparsely enough for each busy window to end before the next one starts. They also assume that software times its time and alarm writes by polling busy. The bench raises `ref_tick` once every four clocks, which keeps the 8-clock window inside a 32-clock copy period. It issues accepted writes only just after it has seen busy fall, and it makes its one deliberate write inside the window just after it has seen busy rise.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int DATA_W      = 32;
   localparam int NUM_SEC_ALM = 2;
   localparam int NUM_EVT     = 5;

   // byte offsets decoded by software
   localparam logic [7:0] OFS_BUSY   = 8'h04;
   localparam logic [7:0] OFS_SEC    = 8'h08;
   localparam logic [7:0] OFS_SHADOW = 8'h0C;
   localparam logic [7:0] OFS_MS     = 8'h10;
   localparam logic [7:0] OFS_SALM0  = 8'h14;
   localparam logic [7:0] OFS_MSALM  = 8'h1C;
   localparam logic [7:0] OFS_MASK   = 8'h28;
   localparam logic [7:0] OFS_STAT   = 8'h2C;

   // event positions shared by mask and status
   localparam int EV_SALM0 = 0;
   localparam int EV_MSALM = 2;
   localparam int EV_SCDN  = 3;
   localparam int EV_MSCDN = 4;
endpackage

// File: rtl/rtc_copy_seq.sv
module rtc_copy_seq #(
   parameter int COPY_TICKS = 8,
   parameter int BUSY_CLKS  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic busy,
   output logic copy_done
);
   localparam int TCNT_W = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
   localparam int BCNT_W = $clog2(BUSY_CLKS + 1);

   if (COPY_TICKS < 2) begin : g_bad_period
      $error("COPY_TICKS must be at least 2");
   end
   if (BUSY_CLKS < 1) begin : g_bad_window
      $error("BUSY_CLKS must be at least 1");
   end

   logic [TCNT_W-1:0] tick_cnt;
   logic [BCNT_W-1:0] win_cnt;
   logic              start;

   assign start     = tick && (tick_cnt == TCNT_W'(COPY_TICKS - 1));
   assign copy_done = busy && (win_cnt == BCNT_W'(BUSY_CLKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_cnt <= '0;
         win_cnt  <= '0;
         busy     <= 1'b0;
      end else begin
         if (tick) begin
            tick_cnt <= start ? '0 : tick_cnt + 1'b1;
         end
         if (start) begin
            busy    <= 1'b1;
            win_cnt <= '0;
         end else if (copy_done) begin
            busy    <= 1'b0;
         end else if (busy) begin
            win_cnt <= win_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
   parameter int REF_HZ     = 32768,
   parameter int MS_PER_SEC = 1000,
   parameter int SEC_W      = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          sec_wr,
   input  logic                          ms_wr,
   input  logic [SEC_W-1:0]              wdata,
   output logic [SEC_W-1:0]              sec,
   output logic [$clog2(MS_PER_SEC)-1:0] ms,
   output logic                          sec_adv,
   output logic                          ms_adv
);
   localparam int ACC_W  = $clog2(REF_HZ) + 1;
   localparam int MS_W   = $clog2(MS_PER_SEC);
   localparam int MS_MAX = MS_PER_SEC - 1;

   if (MS_PER_SEC >= REF_HZ) begin : g_bad_ratio
      $error("MS_PER_SEC must be below REF_HZ");
   end

   logic [ACC_W-1:0] acc, acc_sum;
   logic             carry;

   always_comb begin
      acc_sum = acc + ACC_W'(MS_PER_SEC);
      carry   = (acc_sum >= ACC_W'(REF_HZ));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc     <= '0;
         ms      <= '0;
         sec     <= '0;
         ms_adv  <= 1'b0;
         sec_adv <= 1'b0;
      end else begin
         ms_adv  <= 1'b0;
         sec_adv <= 1'b0;
         if (ms_wr) begin
            ms  <= (wdata > SEC_W'(MS_MAX)) ? MS_W'(MS_MAX) : wdata[MS_W-1:0];
            acc <= '0;
         end else if (tick) begin
            acc <= carry ? acc_sum - ACC_W'(REF_HZ) : acc_sum;
            if (carry) begin
               ms_adv <= 1'b1;
               if (ms == MS_W'(MS_MAX)) begin
                  ms <= '0;
                  if (!sec_wr) begin
                     sec     <= sec + 1'b1;
                     sec_adv <= 1'b1;
                  end
               end else begin
                  ms <= ms + 1'b1;
               end
            end
         end
         if (sec_wr) begin
            sec <= wdata;
         end
      end
   end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] count,
   input  logic [W-1:0] target,
   output logic         hit
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit <= 1'b0;
      end else begin
         hit <= adv && (target != '0) && (count == target);
      end
   end
endmodule

// File: rtl/rtc_shadow_timer.sv
module rtc_shadow_timer
   import rtc_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int REF_HZ     = 32768,
   parameter int MS_PER_SEC = 1000,
   parameter int COPY_TICKS = 8,
   parameter int BUSY_CLKS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   localparam int WORD_W = ADDR_W - 2;
   localparam int MS_W   = $clog2(MS_PER_SEC);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x2C");
   end

   logic [WORD_W-1:0] word_addr;
   assign word_addr = bus_addr[ADDR_W-1:2];

   function automatic logic at(input logic [7:0] ofs);
      return word_addr == WORD_W'(ofs >> 2);
   endfunction

   logic busy, copy_done;
   logic wr, rd, wr_ok;
   assign wr    = bus_en && bus_we;
   assign rd    = bus_en && !bus_we;
   assign wr_ok = wr && !busy;

   logic wr_sec, wr_ms, wr_alm1_w, rd_ms_w, wr_stat_w;
   assign wr_sec    = wr_ok && at(OFS_SEC);
   assign wr_ms     = wr_ok && at(OFS_MS);
   assign wr_alm1_w = wr && at(OFS_SALM0 + 8'd4);
   assign rd_ms_w   = rd && at(OFS_MS);
   assign wr_stat_w = wr && at(OFS_STAT);

   // copy window sequencer
   rtc_copy_seq #(.COPY_TICKS(COPY_TICKS), .BUSY_CLKS(BUSY_CLKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick),
      .busy(busy), .copy_done(copy_done)
   );

   // live counters
   logic [DATA_W-1:0] sec_core;
   logic [MS_W-1:0]   ms_core;
   logic              sec_adv, ms_adv;

   rtc_timebase #(.REF_HZ(REF_HZ), .MS_PER_SEC(MS_PER_SEC), .SEC_W(DATA_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick),
      .sec_wr(wr_sec), .ms_wr(wr_ms), .wdata(bus_wdata),
      .sec(sec_core), .ms(ms_core), .sec_adv(sec_adv), .ms_adv(ms_adv)
   );

   // alarm registers and compares
   logic [DATA_W-1:0] alm_sec [NUM_SEC_ALM];
   logic [MS_W-1:0]   alm_ms;
   logic [NUM_EVT-1:0] ev_hit;

   for (genvar g = 0; g < NUM_SEC_ALM; g++) begin : g_salm
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            alm_sec[g] <= '0;
         end else if (wr_ok && at(OFS_SALM0 + 8'(4 * g))) begin
            alm_sec[g] <= bus_wdata;
         end
      end
      rtc_alarm_cmp #(.W(DATA_W)) u_cmp (
         .clk(clk), .rst_n(rst_n), .adv(sec_adv),
         .count(sec_core), .target(alm_sec[g]), .hit(ev_hit[EV_SALM0 + g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alm_ms <= '0;
      end else if (wr_ok && at(OFS_MSALM)) begin
         alm_ms <= bus_wdata[MS_W-1:0];
      end
   end

   rtc_alarm_cmp #(.W(MS_W)) u_ms_cmp (
      .clk(clk), .rst_n(rst_n), .adv(ms_adv),
      .count(ms_core), .target(alm_ms), .hit(ev_hit[EV_MSALM])
   );

   // countdown events are reserved: never raised
   assign ev_hit[EV_SCDN]  = 1'b0;
   assign ev_hit[EV_MSCDN] = 1'b0;

   // mask and write-one-to-clear status
   logic [NUM_EVT-1:0] mask_q, stat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         if (wr && at(OFS_MASK)) begin
            mask_q <= bus_wdata[NUM_EVT-1:0];
         end
         stat_q <= (stat_q & ~(wr_stat_w ? bus_wdata[NUM_EVT-1:0] : '0)) | ev_hit;
      end
   end

   assign irq = |(stat_q & mask_q);

   // published copy and shadow
   logic [DATA_W-1:0] sec_view, shadow_q;
   logic [MS_W-1:0]   ms_view;
   logic              refresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_view  <= '0;
         ms_view   <= '0;
         shadow_q  <= '0;
         refresh_q <= 1'b0;
      end else begin
         refresh_q <= wr_sec || wr_ms;
         if (copy_done || refresh_q) begin
            sec_view <= sec_core;
            ms_view  <= ms_core;
         end
         if (rd_ms_w) begin
            shadow_q <= sec_view;
         end
      end
   end

   // read mux
   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (at(OFS_BUSY))        rd_mux = {31'd0, busy};
      else if (at(OFS_SEC))    rd_mux = sec_view;
      else if (at(OFS_SHADOW)) rd_mux = shadow_q;
      else if (at(OFS_MS))     rd_mux = 32'(ms_view);
      else if (at(OFS_MSALM))  rd_mux = 32'(alm_ms);
      else if (at(OFS_MASK))   rd_mux = 32'(mask_q);
      else if (at(OFS_STAT))   rd_mux = 32'(stat_q);
      else begin
         for (int k = 0; k < NUM_SEC_ALM; k++) begin
            if (at(OFS_SALM0 + 8'(4 * k))) rd_mux = alm_sec[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd) begin
         bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/rtc_shadow_timer_chk.sv
module rtc_shadow_timer_chk #(
   parameter int MS_PER_SEC = 1000,
   parameter int MS_W       = 10
) (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        wr_alm1,
   input logic [31:0] alm1,
   input logic        rd_ms,
   input logic [31:0] shadow,
   input logic [MS_W-1:0] ms_core,
   input logic [4:0]  stat,
   input logic [4:0]  hit,
   input logic        wr_stat,
   input logic [31:0] wdata
);
   assert_ms_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ms_core <= MS_W'(MS_PER_SEC - 1));

   assert_busy_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_alm1 && busy) |=> $stable(alm1));

   assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ms |=> $stable(shadow));

   assert_alarm0_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[0]) |-> $past(hit[0]));

   assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[1] && !hit[1]) |=> !stat[1]);

   assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stat[4:3] == 2'b00);
endmodule

bind rtc_shadow_timer rtc_shadow_timer_chk #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .wr_alm1(wr_alm1_w), .alm1(alm_sec[1]),
   .rd_ms(rd_ms_w), .shadow(shadow_q), .ms_core(ms_core), .stat(stat_q),
   .hit(ev_hit), .wr_stat(wr_stat_w), .wdata(bus_wdata)
);

// File: tb/test_rtc_shadow_timer.sv
module test_rtc_shadow_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rtc_shadow_timer i_rtc_shadow_timer (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0C, A_MS = 8'h10,
                          A_AL0 = 8'h14, A_AL1 = 8'h18, A_MSAL = 8'h1C,
                          A_MASK = 8'h28, A_STAT = 8'h2C;

   // reference strobe every 4 clocks
   initial begin
      forever begin
         @(negedge clk);
         ref_tick = rst_n && (cyc % 4 == 0);
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input logic [31:0] act,
                          input logic [31:0] lo, input logic [31:0] hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wait_busy(input logic lvl);
      logic [31:0] v;
      v = ~32'(lvl);
      while (v[0] !== lvl) rd(A_BUSY, v);
   endtask

   // write just after busy falls
   task automatic wr_safe(input logic [7:0] a, input logic [31:0] d);
      wait_busy(1'b1);
      wait_busy(1'b0);
      wr_raw(a, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   typedef struct packed {
      logic [7:0]  addr;
      logic [31:0] wdata;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{A_AL0,  32'h1234_5678, 32'h1234_5678},  // R5 accepted outside busy
      '{A_AL1,  32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R5
      '{A_MSAL, 32'hFFFF_F123, 32'h0000_0123},  // R8 10-bit field
      '{A_MASK, 32'hFFFF_FFFF, 32'h0000_001F},  // R11 mask keeps 4:0
      '{A_MASK, 32'h0000_0000, 32'h0000_0000},  // R11
      '{A_STAT, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 clearing empty status
      '{A_SHD,  32'h0000_AAAA, 32'h0000_0000},  // R6 shadow not writable
      '{A_AL0,  32'h0000_0000, 32'h0000_0000},  // R7
      '{A_AL1,  32'h0000_0000, 32'h0000_0000},  // R7
      '{A_MSAL, 32'h0000_0000, 32'h0000_0000}   // R8
   };

   initial begin
      logic [31:0] v;
      int ones, rises, first_rise, second_rise, run, max_run;
      logic prev;

      idle(4);
      rst_n = 1'b1;

      // R1 reset state
      foreach (VECS[k]) begin end
      rd(A_BUSY, v); chk("R1 busy", v, 0);
      rd(A_SEC, v);  chk("R1 seconds", v, 0);
      rd(A_SHD, v);  chk("R1 shadow", v, 0);
      rd(A_MS, v);   chk("R1 ms", v, 0);
      rd(A_AL0, v);  chk("R1 alarm0", v, 0);
      rd(A_AL1, v);  chk("R1 alarm1", v, 0);
      rd(A_MSAL, v); chk("R1 ms alarm", v, 0);
      rd(A_MASK, v); chk("R1 mask", v, 0);
      rd(A_STAT, v); chk("R1 status", v, 0);
      chk("R1 irq", 32'(irq), 0);

      // R4 busy window length and period
      prev = 1'b0; run = 0; max_run = 0; rises = 0; first_rise = 0; second_rise = 0;
      for (int i = 0; i < 120; i++) begin
         rd(A_BUSY, v);
         if (v[0]) run++;
         if (v[0] && !prev) begin
            rises++;
            if (rises == 1) first_rise = i;
            if (rises == 2) second_rise = i;
         end
         if (!v[0] && prev && rises >= 1) begin
            if (run > max_run) max_run = run;
            run = 0;
         end
         if (!v[0]) run = 0;
         prev = v[0];
      end
      chk("R4 busy length", 32'(max_run), 8);
      chk("R4 busy period", 32'(second_rise - first_rise), 32);

      // vector table
      for (int i = 0; i < NV; i++) begin
         wr_safe(VECS[i].addr, VECS[i].wdata);
         rd(VECS[i].addr, v);
         chk($sformatf("R5/R6/R8/R9/R11 vector %0d", i), v, VECS[i].exp);
      end

      // R5 write inside busy window dropped
      wait_busy(1'b1);
      wr_raw(A_AL1, 32'h55);
      rd(A_AL1, v); chk("R5 write during busy", v, 0);

      // R2 counting rate and R6 shadow
      wr_safe(A_SEC, 32'd1000);
      wr_safe(A_MS, 32'd100);
      idle(2000);
      rd(A_MS, v);  chk_rng("R2 ms advance", v, 113, 116);
      rd(A_SHD, v); chk("R6 shadow capture", v, 32'd1000);

      // R3 seconds increment at ms wrap
      wr_safe(A_SEC, 32'd41);
      wr_safe(A_MS, 32'd998);
      idle(600);
      rd(A_MS, v);  chk_rng("R3 ms after wrap", v, 1, 3);
      rd(A_SHD, v); chk("R3 seconds increment", v, 32'd42);

      // R2 clamp, R3 32-bit wrap, R7 zero alarm disabled
      wr_safe(A_SEC, 32'hFFFF_FFFF);
      wr_safe(A_MS, 32'd5000);
      idle(1);
      rd(A_MS, v);  chk("R2 ms clamp", v, 32'd999);
      idle(300);
      rd(A_MS, v);  rd(A_SHD, v); chk("R3 seconds wrap", v, 0);
      rd(A_STAT, v); chk("R7 zero alarm silent", v, 0);

      // R7 alarm0, R10 irq, R9 clear
      wr_safe(A_AL0, 32'd8);
      wr_safe(A_MASK, 32'h1);
      wr_safe(A_SEC, 32'd7);
      wr_safe(A_MS, 32'd999);
      idle(300);
      rd(A_STAT, v); chk("R7 alarm0 status", v, 32'h1);
      chk("R10 irq on", 32'(irq), 1);
      wr_raw(A_MASK, 32'h0);
      chk("R10 irq masked", 32'(irq), 0);
      wr_raw(A_MASK, 32'h1);
      chk("R10 irq unmasked", 32'(irq), 1);
      wr_raw(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R9 write zero keeps", v, 32'h1);
      wr_raw(A_STAT, 32'h1);
      rd(A_STAT, v); chk("R9 write one clears", v, 0);
      chk("R10 irq off", 32'(irq), 0);
      wr_safe(A_AL0, 32'd0);

      // R7 alarm1
      wr_safe(A_AL1, 32'd20);
      wr_safe(A_SEC, 32'd19);
      wr_safe(A_MS, 32'd999);
      idle(300);
      rd(A_STAT, v); chk("R7 alarm1 status", v, 32'h2);
      chk("R10 irq stays low unmasked bit", 32'(irq), 0);
      wr_raw(A_STAT, 32'h2);
      wr_safe(A_AL1, 32'd0);

      // R8 ms alarm, R11 reserved bits clear
      wr_safe(A_MSAL, 32'd3);
      wr_safe(A_MS, 32'd1);
      idle(400);
      rd(A_STAT, v); chk("R8 ms alarm status, R11 bits 4:3 zero", v, 32'h4);
      wr_raw(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, v); chk("R9 clear all", v, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule